// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Block

This block is a reconfigurable two-level logic core: an AND plane forms product terms from a vector of inputs and their complements, and a steering stage ORs any chosen subset of those terms into each of several sum outputs. The product terms form one shared pool. Any term can reach any output, and one term can feed several outputs at the same time, so a term that several outputs need is built only once. The number of terms per output can be anything from none up to a fixed ceiling.

Both configuration banks sit in registers that are loaded one addressed word at a time through a write-enable port. A synchronous reset clears every configuration bit. The sum outputs are combinational functions of the stored configuration and the current inputs. When an output's selection asks for more terms than the ceiling allows, the block raises an error bit for that output and keeps only the lowest-numbered selected terms, up to the ceiling.

Top module: `pt_logic_block`

## Requirements
- R1: Input i appears to the AND plane as two literals: bit 2i of a term row selects the true value of input i, and bit 2i+1 selects its complement. A product term is the AND of the literals its row selects.
- R2: A product term whose row selects no literal evaluates to 0, whatever the inputs.
- R3: Write addresses 0 to 85 load term rows 0 to 85 from data bits 71:0. Addresses 86 to 101 load the selection rows of outputs 0 to 15 from data bits 85:0, where bit t selects term t.
- R4: Each sum output is the OR of the terms its selection row picks. An output that picks no term is 0.
- R5: One product term selected by several outputs drives all of them at the same time.
- R6: When an output selects more than 16 terms, its error bit is 1 and only the 16 lowest-numbered selected terms contribute to its sum.
- R7: Synchronous reset clears both configuration banks, so all sum outputs and all error bits read 0 after reset.
- R8: A write to an address above 101 changes no configuration. Data bits 85:72 of a term-row write are ignored.
- R9: Sum outputs follow input changes in the same cycle. A configuration write takes effect from the clock edge that captures it, and not before that edge.
- R10: An output that selects exactly 16 terms has its error bit at 0 and uses all 16 terms.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the configuration registers |
| rst | input | 1 | Synchronous reset, active high; clears all configuration |
| cfg_we | input | 1 | Write enable for one configuration word |
| cfg_addr | input | 7 | Word address: term rows, then output selection rows |
| cfg_wdata | input | 86 | Configuration word data |
| in_vec | input | 36 | Logic inputs to the AND plane |
| sum_out | output | 16 | One sum term per macrocell |
| cap_err | output | 16 | Per-output flag: more terms selected than the ceiling |

## Verification
The sum and error outputs have no register between the inputs and the outputs, so a change on in_vec is due within the same cycle. The bench drives inputs on the falling edge and samples one nanosecond later. A configuration write is due one clock edge after cfg_we is raised. The bench checks the old value between raising cfg_we and the rising edge, then checks the new value just after that edge. Reset is checked in the same way, on the first edge after reset is released.

// File: rtl/pt_pkg.sv
package pt_pkg;
  // default geometry of one logic block
  localparam int PT_INPUTS = 36;
  localparam int PT_TERMS  = 86;
  localparam int PT_OUTS   = 16;
  localparam int PT_CAP    = 16;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic int addr_bits(input int words);
    int b;
    b = 1;
    while ((1 << b) < words) b++;
    return b;
  endfunction
endpackage

// File: rtl/pt_cfg_store.sv
module pt_cfg_store #(
  parameter int N_LIT  = 72,
  parameter int N_PT   = 86,
  parameter int N_MC   = 16,
  parameter int ADDR_W = 7,
  parameter int DW     = 86
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        we,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [DW-1:0]               wdata,
  output logic [N_PT-1:0][N_LIT-1:0]  term_rows,
  output logic [N_MC-1:0][N_PT-1:0]   sel_rows
);
  // one decoded write strobe per stored word
  logic [N_PT-1:0] term_hit;
  logic [N_MC-1:0] sel_hit;

  for (genvar t = 0; t < N_PT; t++) begin : g_term
    assign term_hit[t] = we && (addr == ADDR_W'(t));

    always_ff @(posedge clk) begin
      if (rst)              term_rows[t] <= '0;
      else if (term_hit[t]) term_rows[t] <= wdata[N_LIT-1:0];
    end

    // R3: a term-row write lands in the addressed row
    p_term_write_r3: assert property (@(posedge clk) disable iff (rst)
      (we && addr == ADDR_W'(t)) |=> (term_rows[t] == $past(wdata[N_LIT-1:0])));
    // R7: reset empties each term row
    p_term_reset_r7: assert property (@(posedge clk)
      rst |=> (term_rows[t] == '0));
  end

  for (genvar m = 0; m < N_MC; m++) begin : g_sel
    assign sel_hit[m] = we && (addr == ADDR_W'(N_PT + m));

    always_ff @(posedge clk) begin
      if (rst)             sel_rows[m] <= '0;
      else if (sel_hit[m]) sel_rows[m] <= wdata[N_PT-1:0];
    end

    // R3: a selection-row write lands in the addressed row
    p_sel_write_r3: assert property (@(posedge clk) disable iff (rst)
      (we && addr == ADDR_W'(N_PT + m)) |=> (sel_rows[m] == $past(wdata[N_PT-1:0])));
    // R7: reset empties each selection row
    p_sel_reset_r7: assert property (@(posedge clk)
      rst |=> (sel_rows[m] == '0));
  end

  // R8: at most one word is written per cycle
  p_one_hot_write_r8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({term_hit, sel_hit}));
endmodule

// File: rtl/pt_and_plane.sv
module pt_and_plane #(
  parameter int N_IN = 36,
  parameter int N_PT = 86,
  parameter int N_LIT = 2 * N_IN
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [N_IN-1:0]             in_vec,
  input  logic [N_PT-1:0][N_LIT-1:0]  term_rows,
  output logic [N_PT-1:0]             terms
);
  logic [N_LIT-1:0] lits;

  // literal 2i is input i, literal 2i+1 is its complement
  function automatic logic [N_LIT-1:0] expand(input logic [N_IN-1:0] v);
    logic [N_LIT-1:0] l;
    for (int i = 0; i < N_IN; i++) begin
      l[2*i]   = v[i];
      l[2*i+1] = ~v[i];
    end
    return l;
  endfunction

  // a term is true when it has at least one literal and all of them hold
  function automatic logic eval_term(input logic [N_LIT-1:0] row,
                                     input logic [N_LIT-1:0] l);
    return (|row) && (&(l | ~row));
  endfunction

  assign lits = expand(in_vec);

  for (genvar t = 0; t < N_PT; t++) begin : g_pt
    assign terms[t] = eval_term(term_rows[t], lits);

    // R2: an empty row never produces a true term
    p_blank_term_low_r2: assert property (@(posedge clk) disable iff (rst)
      (term_rows[t] == '0) |-> !terms[t]);
  end
endmodule

// File: rtl/pt_steer.sv
module pt_steer #(
  parameter int N_PT = 86,
  parameter int N_MC = 16,
  parameter int CAP  = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [N_PT-1:0]            terms,
  input  logic [N_MC-1:0][N_PT-1:0]  sel_rows,
  output logic [N_MC-1:0]            sums,
  output logic [N_MC-1:0]            over
);
  logic [N_MC-1:0][N_PT-1:0] used;

  function automatic int count_sel(input logic [N_PT-1:0] s);
    int n;
    n = 0;
    for (int t = 0; t < N_PT; t++) n += int'(s[t]);
    return n;
  endfunction

  // keep the lowest-numbered selected terms, at most CAP of them
  function automatic logic [N_PT-1:0] keep_low(input logic [N_PT-1:0] s);
    logic [N_PT-1:0] k;
    int seen;
    k = '0;
    seen = 0;
    for (int t = 0; t < N_PT; t++) begin
      if (s[t] && seen < CAP) begin
        k[t] = 1'b1;
        seen++;
      end
    end
    return k;
  endfunction

  for (genvar m = 0; m < N_MC; m++) begin : g_mc
    assign used[m] = keep_low(sel_rows[m]);
    assign over[m] = count_sel(sel_rows[m]) > CAP;
    assign sums[m] = |(terms & used[m]);

    // R6: no output ever uses more than the ceiling
    p_cap_bound_r6: assert property (@(posedge clk) disable iff (rst)
      $countones(used[m]) <= CAP);
    // R6: a flagged output uses exactly the ceiling
    p_flag_full_r6: assert property (@(posedge clk) disable iff (rst)
      over[m] |-> ($countones(used[m]) == CAP));
    // R4: an output with nothing selected stays low
    p_no_sel_low_r4: assert property (@(posedge clk) disable iff (rst)
      (sel_rows[m] == '0) |-> !sums[m]);
  end
endmodule

// File: rtl/pt_logic_block.sv
module pt_logic_block
  import pt_pkg::*;
#(
  parameter int N_IN = PT_INPUTS,
  parameter int N_PT = PT_TERMS,
  parameter int N_MC = PT_OUTS,
  parameter int CAP  = PT_CAP,
  localparam int N_LIT   = 2 * N_IN,
  localparam int N_WORDS = N_PT + N_MC,
  localparam int ADDR_W  = addr_bits(N_WORDS),
  localparam int DW      = max_of(N_LIT, N_PT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [DW-1:0]     cfg_wdata,
  input  logic [N_IN-1:0]   in_vec,
  output logic [N_MC-1:0]   sum_out,
  output logic [N_MC-1:0]   cap_err
);
  logic [N_PT-1:0][N_LIT-1:0] term_rows;
  logic [N_MC-1:0][N_PT-1:0]  sel_rows;
  logic [N_PT-1:0]            terms;
  logic                       wr_outside;

  assign wr_outside = cfg_we && (cfg_addr >= ADDR_W'(N_WORDS));

  pt_cfg_store #(
    .N_LIT(N_LIT), .N_PT(N_PT), .N_MC(N_MC), .ADDR_W(ADDR_W), .DW(DW)
  ) i_store (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .term_rows(term_rows), .sel_rows(sel_rows)
  );

  pt_and_plane #(
    .N_IN(N_IN), .N_PT(N_PT), .N_LIT(N_LIT)
  ) i_and (
    .clk(clk), .rst(rst), .in_vec(in_vec), .term_rows(term_rows), .terms(terms)
  );

  pt_steer #(
    .N_PT(N_PT), .N_MC(N_MC), .CAP(CAP)
  ) i_steer (
    .clk(clk), .rst(rst), .terms(terms), .sel_rows(sel_rows),
    .sums(sum_out), .over(cap_err)
  );

  // R8: a write outside the map leaves the outputs as they were
  p_outside_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    wr_outside |=> (!$stable(in_vec) || ($stable(sum_out) && $stable(cap_err))));
  // R7: the cycle after reset shows no sums and no errors
  p_reset_outputs_r7: assert property (@(posedge clk)
    rst |=> (sum_out == '0 && cap_err == '0));
endmodule

// File: tb/test_pt_logic_block.sv
module test_pt_logic_block;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_addr = '0;
  logic [85:0] cfg_wdata = '0;
  logic [35:0] in_vec = '0;
  logic [15:0] sum_out;
  logic [15:0] cap_err;

  int total = 0;
  int bad = 0;

  always #4 clk = ~clk;

  pt_logic_block i_pt_logic_block (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_vec(in_vec), .sum_out(sum_out), .cap_err(cap_err)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [85:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 7'(a); cfg_wdata = d;
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
  endtask

  task automatic set_in(input logic [35:0] v);
    @(negedge clk);
    in_vec = v;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(posedge clk);
    #1;
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    set_in('1);
    check("R7 sums after reset", sum_out, 16'h0);
    check("R7 errors after reset", cap_err, 16'h0);
  endtask

  task automatic t_literals();
    wr(0, 86'b1001);            // term 0 = in0 & ~in1
    wr(86, 86'b1);              // output 0 <- term 0
    set_in(36'b01);
    check("R1 in0=1 in1=0", {15'b0, sum_out[0]}, 16'h1);
    set_in(36'b11);
    check("R1 in0=1 in1=1", {15'b0, sum_out[0]}, 16'h0);
    set_in(36'b00);
    check("R4 in0=0", {15'b0, sum_out[0]}, 16'h0);
  endtask

  task automatic t_empty_term();
    wr(86 + 1, 86'b10);         // output 1 <- term 1, term 1 never written
    set_in('1);
    check("R2 empty term all ones", {15'b0, sum_out[1]}, 16'h0);
    set_in('0);
    check("R2 empty term all zeros", {15'b0, sum_out[1]}, 16'h0);
  endtask

  task automatic t_share();
    wr(2, 86'(1) << 70);        // term 2 = in35
    for (int m = 2; m <= 4; m++) wr(86 + m, 86'b100);
    wr(86 + 5, 86'b101);        // output 5 <- term 0 | term 2
    wr(86 + 6, 86'b0);
    set_in(36'(1) << 35);
    check("R5 shared term", {13'b0, sum_out[4:2]}, 16'h7);
    check("R4 OR of two terms, term2", {15'b0, sum_out[5]}, 16'h1);
    check("R4 no terms selected", {15'b0, sum_out[6]}, 16'h0);
    set_in(36'b01);
    check("R5 shared term low", {13'b0, sum_out[4:2]}, 16'h0);
    check("R4 OR of two terms, term0", {15'b0, sum_out[5]}, 16'h1);
  endtask

  task automatic t_cap();
    logic [85:0] m18;
    logic [85:0] m16;
    m18 = '0;
    m16 = '0;
    for (int t = 10; t < 28; t++) begin
      wr(t, 86'(1) << (2 * (t - 10)));   // term t = in(t-10)
      m18[t] = 1'b1;
      if (t < 26) m16[t] = 1'b1;
    end
    wr(86 + 7, m18);
    wr(86 + 8, m16);
    set_in(36'(1) << 16);                // term 26 only
    check("R6 error flag", {15'b0, cap_err[7]}, 16'h1);
    check("R6 17th term dropped", {15'b0, sum_out[7]}, 16'h0);
    check("R10 exactly 16 no error", {15'b0, cap_err[8]}, 16'h0);
    set_in(36'(1) << 15);                // term 25 only
    check("R6 16th term kept", {15'b0, sum_out[7]}, 16'h1);
    check("R10 16th term used", {15'b0, sum_out[8]}, 16'h1);
  endtask

  task automatic t_ignored();
    logic [15:0] s_before;
    logic [15:0] e_before;
    wr(3, 86'h3FFF << 72);      // only ignored high bits
    wr(86 + 9, 86'b1000);       // output 9 <- term 3
    set_in('1);
    check("R8 high bits ignored ones", {15'b0, sum_out[9]}, 16'h0);
    set_in('0);
    check("R8 high bits ignored zeros", {15'b0, sum_out[9]}, 16'h0);
    s_before = sum_out;
    e_before = cap_err;
    wr(120, '1);
    #1;
    check("R8 outside address sums", sum_out, s_before);
    check("R8 outside address errors", cap_err, e_before);
  endtask

  task automatic t_timing();
    set_in(36'(1) << 4);
    check("R9 before rewrite", {15'b0, sum_out[0]}, 16'h0);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 7'd0; cfg_wdata = 86'(1) << 8;  // term 0 = in4
    #1;
    check("R9 not before edge", {15'b0, sum_out[0]}, 16'h0);
    @(posedge clk);
    #1;
    cfg_we = 1'b0;
    check("R9 after edge", {15'b0, sum_out[0]}, 16'h1);
    set_in(36'b0);
    check("R9 same-cycle input", {15'b0, sum_out[0]}, 16'h0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    #1;
    rst = 1'b0;
    t_reset();
    t_literals();
    t_empty_term();
    t_share();
    t_cap();
    t_ignored();
    t_timing();
    t_reset();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule